// File: doc/BRIEF.md
# Recovered Clock Frequency Lock Monitor

This block compares a recovered line clock with the local master clock. It reports loss of lock when the two frequencies drift too far apart. A gate window of 2^GATE_LOG2 master-clock cycles is generated, and the recovered-clock cycles inside each window are counted. At the end of each window the count is compared with the nominal count `EXP_CNT`. The absolute difference is checked against two thresholds derived from ppm limits when the design is elaborated. These two thresholds give asymmetric hysteresis on a loss-of-lock status bit.

The recovered-clock domain also runs a watchdog on a divided copy of the master clock. If that copy stops toggling for `WD_LIMIT` recovered cycles, the current window is tagged as taken without a reference, and its result forces the status clear. Window results pass back to the master domain through a toggle handshake. Any change of the status sets a sticky interrupt-pending bit. Software clears that bit with a write-one-to-clear pulse, and the interrupt output is the pending bit gated by an enable.

Top module: `freq_lock_mon`

## Requirements
- R1: At a window end whose reference was present, the status `lol_o` becomes 1 when |count − EXP_CNT| > floor(EXP_CNT·SET_PPM/10^6).
- R2: At a window end, `lol_o` becomes 0 when |count − EXP_CNT| < floor(EXP_CNT·CLR_PPM/10^6).
- R3: When the difference lies between the two thresholds, or between window ends, `lol_o` keeps its value.
- R4: Every change of `lol_o`, in either direction, sets `irq_pend_o`. The bit stays set until a cycle with `irq_clr_i` = 1, which clears it.
- R5: `irq_o` equals `irq_pend_o` AND `irq_en_i`. The enable has no effect on `irq_pend_o`.
- R6: If a status change and `irq_clr_i` fall in the same master cycle, the pending bit ends set.
- R7: If the divided master clock is not seen to toggle for `WD_LIMIT` recovered cycles during a window, that window's result forces `lol_o` to 0, whatever the count.
- R8: After reset, `lol_o`, `irq_pend_o` and `irq_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master reference clock |
| rclk_i | input | 1 | Recovered line clock |
| rst_ni | input | 1 | Active-low asynchronous reset, both domains |
| irq_en_i | input | 1 | Interrupt enable |
| irq_clr_i | input | 1 | Write-one-to-clear pulse for the pending bit |
| lol_o | output | 1 | Loss-of-lock status bit |
| irq_pend_o | output | 1 | Sticky change-of-status bit |
| irq_o | output | 1 | Interrupt request |

## Verification
A status change and a software clear of the pending bit can fall in the same master cycle. The bench holds `irq_clr_i` high for several whole windows while the recovered-clock period moves the status across a threshold. It then counts the cycles in which `irq_o` is high, and exactly one such cycle shows that the set won. The bench also stalls the master clock in the middle of a window, so that the inflated count and the missing-reference tag reach the evaluation together; the status must stay clear.

// File: rtl/flm_pkg.sv
package flm_pkg;
  function automatic int unsigned ppm_thr(input int unsigned nom, input int unsigned ppm);
    longint unsigned p;
    p = (longint'(nom) * longint'(ppm)) / 64'd1000000;
    return int'(p);
  endfunction
endpackage

// File: rtl/flm_sync.sv
module flm_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr <= '0;
    else         sr <= {sr[STAGES-2:0], d_i};
  end
  assign q_o = sr[STAGES-1];
endmodule

// File: rtl/flm_gate.sv
module flm_gate #(
  parameter int GATE_LOG2 = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic gate_tgl_o,
  output logic mdiv_o
);
  logic [GATE_LOG2-1:0] cnt;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt        <= '0;
      gate_tgl_o <= 1'b0;
    end else begin
      cnt <= cnt + 1'b1;
      if (&cnt) gate_tgl_o <= ~gate_tgl_o;
    end
  end
  // divide by 4 so the recovered side can sample it
  assign mdiv_o = cnt[1];
endmodule

// File: rtl/flm_rcount.sv
module flm_rcount #(
  parameter int CW          = 18,
  parameter int WD_LIMIT    = 256,
  parameter int SYNC_STAGES = 2
) (
  input  logic          rclk_i,
  input  logic          rst_ni,
  input  logic          gate_tgl_i,
  input  logic          mdiv_i,
  output logic [CW-1:0] cap_cnt_o,
  output logic          cap_abs_o,
  output logic          done_tgl_o
);
  localparam int WDW = $clog2(WD_LIMIT + 1);
  localparam logic [WDW-1:0] WD_TOP = WDW'(WD_LIMIT - 1);

  logic gate_s, gate_q, mdiv_s, mdiv_q, edge_seen;
  logic [CW-1:0]  cnt;
  logic [WDW-1:0] wd_cnt;
  logic           wd_hit, abs_acc;

  flm_sync #(.STAGES(SYNC_STAGES)) u_sync_gate (.clk_i(rclk_i), .rst_ni(rst_ni), .d_i(gate_tgl_i), .q_o(gate_s));
  flm_sync #(.STAGES(SYNC_STAGES)) u_sync_mdiv (.clk_i(rclk_i), .rst_ni(rst_ni), .d_i(mdiv_i),     .q_o(mdiv_s));

  assign edge_seen = gate_s ^ gate_q;
  assign wd_hit    = (wd_cnt == WD_TOP);

  always_ff @(posedge rclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gate_q <= 1'b0;
      mdiv_q <= 1'b0;
      wd_cnt <= '0;
    end else begin
      gate_q <= gate_s;
      mdiv_q <= mdiv_s;
      if (mdiv_s != mdiv_q) wd_cnt <= '0;
      else if (!wd_hit)     wd_cnt <= wd_cnt + 1'b1;
    end
  end

  always_ff @(posedge rclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt        <= '0;
      abs_acc    <= 1'b0;
      cap_cnt_o  <= '0;
      cap_abs_o  <= 1'b0;
      done_tgl_o <= 1'b0;
    end else if (edge_seen) begin
      cap_cnt_o  <= cnt;
      cap_abs_o  <= abs_acc | wd_hit;
      done_tgl_o <= ~done_tgl_o;
      cnt        <= CW'(1);
      abs_acc    <= 1'b0;
    end else begin
      if (!(&cnt)) cnt <= cnt + 1'b1;
      if (wd_hit)  abs_acc <= 1'b1;
    end
  end

  a_r7_abs_latched: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    (wd_hit && !edge_seen) |=> abs_acc);
endmodule

// File: rtl/flm_eval.sv
module flm_eval #(
  parameter int CW          = 18,
  parameter int EXP_CNT     = 65536,
  parameter int SET_THR     = 517,
  parameter int CLR_THR     = 504,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [CW-1:0] cap_cnt_i,
  input  logic          cap_abs_i,
  input  logic          done_tgl_i,
  input  logic          irq_en_i,
  input  logic          irq_clr_i,
  output logic          lol_o,
  output logic          irq_pend_o,
  output logic          irq_o
);
  localparam logic [CW-1:0] EXP_V = CW'(EXP_CNT);
  localparam logic [CW-1:0] SET_V = CW'(SET_THR);
  localparam logic [CW-1:0] CLR_V = CW'(CLR_THR);

  logic done_s, done_q, res_vld, lol_nxt;
  logic [CW-1:0] diff;

  flm_sync #(.STAGES(SYNC_STAGES)) u_sync_done (.clk_i(clk_i), .rst_ni(rst_ni), .d_i(done_tgl_i), .q_o(done_s));

  // capture regs are held a full window, safe to read after the toggle lands
  assign res_vld = done_s ^ done_q;
  assign diff    = (cap_cnt_i >= EXP_V) ? cap_cnt_i - EXP_V : EXP_V - cap_cnt_i;

  always_comb begin
    lol_nxt = lol_o;
    if (res_vld) begin
      if (cap_abs_i)          lol_nxt = 1'b0;
      else if (diff > SET_V)  lol_nxt = 1'b1;
      else if (diff < CLR_V)  lol_nxt = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q     <= 1'b0;
      lol_o      <= 1'b0;
      irq_pend_o <= 1'b0;
    end else begin
      done_q <= done_s;
      lol_o  <= lol_nxt;
      if (lol_nxt != lol_o) irq_pend_o <= 1'b1;
      else if (irq_clr_i)   irq_pend_o <= 1'b0;
    end
  end

  assign irq_o = irq_pend_o & irq_en_i;

  a_r1_set_above: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_vld && !cap_abs_i && diff > SET_V) |=> lol_o);
  a_r2_clear_below: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_vld && diff < CLR_V) |=> !lol_o);
  a_r3_hold_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !res_vld |=> $stable(lol_o));
  a_r4_change_pends: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lol_o != $past(lol_o)) |-> irq_pend_o);
  a_r4_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_pend_o && !irq_clr_i) |=> irq_pend_o);
  a_r7_no_ref_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_vld && cap_abs_i) |=> !lol_o);
endmodule

// File: rtl/freq_lock_mon.sv
module freq_lock_mon #(
  parameter int GATE_LOG2   = 16,
  parameter int EXP_CNT     = 65536,
  parameter int SET_PPM     = 7900,
  parameter int CLR_PPM     = 7700,
  parameter int WD_LIMIT    = 256,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rclk_i,
  input  logic rst_ni,
  input  logic irq_en_i,
  input  logic irq_clr_i,
  output logic lol_o,
  output logic irq_pend_o,
  output logic irq_o
);
  localparam int CW      = GATE_LOG2 + 2;
  localparam int SET_THR = int'(flm_pkg::ppm_thr(EXP_CNT, SET_PPM));
  localparam int CLR_THR = int'(flm_pkg::ppm_thr(EXP_CNT, CLR_PPM));

  logic          gate_tgl, mdiv, done_tgl, cap_abs;
  logic [CW-1:0] cap_cnt;

  flm_gate #(.GATE_LOG2(GATE_LOG2)) u_gate (
    .clk_i(clk_i), .rst_ni(rst_ni), .gate_tgl_o(gate_tgl), .mdiv_o(mdiv));

  flm_rcount #(.CW(CW), .WD_LIMIT(WD_LIMIT), .SYNC_STAGES(SYNC_STAGES)) u_rcount (
    .rclk_i(rclk_i), .rst_ni(rst_ni), .gate_tgl_i(gate_tgl), .mdiv_i(mdiv),
    .cap_cnt_o(cap_cnt), .cap_abs_o(cap_abs), .done_tgl_o(done_tgl));

  flm_eval #(.CW(CW), .EXP_CNT(EXP_CNT), .SET_THR(SET_THR), .CLR_THR(CLR_THR),
             .SYNC_STAGES(SYNC_STAGES)) u_eval (
    .clk_i(clk_i), .rst_ni(rst_ni), .cap_cnt_i(cap_cnt), .cap_abs_i(cap_abs),
    .done_tgl_i(done_tgl), .irq_en_i(irq_en_i), .irq_clr_i(irq_clr_i),
    .lol_o(lol_o), .irq_pend_o(irq_pend_o), .irq_o(irq_o));

  initial begin
    a_r2_thr_order: assert (CLR_THR <= SET_THR);
  end
endmodule

// File: tb/freq_lock_mon_bench.sv
`timescale 1ns/1ps
module freq_lock_mon_bench;
  localparam int GL = 10;
  localparam int GATE = 1 << GL;

  logic clk = 1'b0, rclk = 1'b0, rst_n = 1'b0, en = 1'b1, clr = 1'b0;
  logic lol, pend, irq;
  bit   mrun = 1'b1;
  realtime rper = 8.0;
  int total = 0, bad = 0;

  // nominal 1024, set thr 102, clear thr 51
  freq_lock_mon #(.GATE_LOG2(GL), .EXP_CNT(GATE), .SET_PPM(100000), .CLR_PPM(50000),
                  .WD_LIMIT(64)) u_freq_lock_mon (
    .clk_i(clk), .rclk_i(rclk), .rst_ni(rst_n), .irq_en_i(en), .irq_clr_i(clr),
    .lol_o(lol), .irq_pend_o(pend), .irq_o(irq));

  always begin #4; if (mrun) clk = ~clk; end
  always begin #(rper/2.0); rclk = ~rclk; end

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic gates(input int n);
    repeat (n * GATE) @(negedge clk);
  endtask

  task automatic clr_pulse();
    @(negedge clk); clr = 1'b1; @(negedge clk); clr = 1'b0; @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int hi;
    #20;
    chk("R8", "lol in reset", lol, 0);
    chk("R8", "irq in reset", irq, 0);
    #3.3 rst_n = 1'b1;
    // counts: 8ns->1024 (d0), 7->1170 (d146), 7.5->1092 (d68), 7.8->1050 (d26), 8.5->963 (d61), 9->910 (d114)
    gates(3);
    chk("R8", "lol nominal", lol, 0);
    chk("R4", "pend no change", pend, 0);
    rper = 7.0; gates(3);
    chk("R1", "lol fast", lol, 1);
    chk("R4", "irq on set", irq, 1);
    clr_pulse();
    chk("R4", "pend after w1c", pend, 0);
    rper = 7.5; gates(3);
    chk("R3", "lol band hold high", lol, 1);
    chk("R4", "no change no pend", pend, 0);
    rper = 7.8; gates(3);
    chk("R2", "lol near nominal", lol, 0);
    chk("R4", "irq on clear", irq, 1);
    clr_pulse();
    rper = 8.5; gates(3);
    chk("R3", "lol band hold low", lol, 0);
    chk("R3", "pend band", pend, 0);
    en = 1'b0;
    rper = 9.0; gates(3);
    chk("R1", "lol slow", lol, 1);
    chk("R5", "irq masked", irq, 0);
    chk("R5", "pend while masked", pend, 1);
    @(negedge clk); en = 1'b1; @(negedge clk);
    chk("R5", "irq unmasked", irq, 1);
    clr_pulse();
    // R6: clear held across the status change
    @(negedge clk); clr = 1'b1;
    rper = 8.0;
    hi = 0;
    for (int i = 0; i < 3 * GATE; i++) begin
      @(negedge clk);
      hi += int'(irq);
    end
    clr = 1'b0;
    chk("R6", "irq high cycles under clear", hi, 1);
    chk("R2", "lol back nominal", lol, 0);
    // R7: stall master mid-window; count would read ~1399 without the tag
    gates(1);
    repeat (GATE / 2) @(negedge clk);
    mrun = 1'b0; #3000; mrun = 1'b1;
    gates(3);
    chk("R7", "lol after ref stall", lol, 0);
    chk("R7", "pend after ref stall", pend, 0);
    rper = 7.0; gates(3);
    chk("R1", "lol fast after stall", lol, 1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule